// File: doc/BRIEF.md
# Accumulator-to-Buffer Activation Unit

This block carries out the activate step of a matrix engine. Once started, it walks a run of N vectors in the accumulator memory, one address per cycle. Each vector is a row of 32-bit signed lanes. The block passes every lane through a selected function: pass-through, ReLU or a hard sigmoid. It keeps the low 8 bits of each result and writes the narrowed vector to consecutive addresses of the unified buffer.

Both memories are reached through plain synchronous ports. The accumulator read port returns data one cycle after the read enable. The buffer write port takes address, data and enable in the same cycle. The function, the addresses and the count are captured on the start pulse. The sigmoid scaling is a build-time parameter and cannot be changed at run time. A run of L vectors keeps busy high for L+1 cycles.

Top module: `act_unit`

## Requirements
- R1: After reset, busy, done, acc_rd_en and ub_wr_en are all low.
- R2: For a start with count N>0, the block issues exactly N accumulator reads on consecutive cycles, at src_addr, src_addr+1, ... (modulo the address width).
- R3: Each read is followed one cycle later by a buffer write, at dst_addr, dst_addr+1, ... (modulo the address width), so there are exactly N writes.
- R4: func_sel 2'b00 (pass-through) writes the low 8 bits of each 32-bit lane (lane i of the word lies in bits [32i+31:32i] and in bits [8i+7:8i] of the output).
- R5: func_sel 2'b01 (ReLU) writes 0 for a negative signed lane, and the low 8 bits of the lane otherwise.
- R6: func_sel 2'b10 (sigmoid) writes clamp(128 + (x >>> 2), 0, 255) for a signed lane x.
- R7: For N>0, busy is high for exactly N+1 cycles. done is a one-cycle pulse in the cycle after the last write, with busy low.
- R8: A start with N=0 pulses done in the next cycle without any read, any write or any busy cycle.
- R9: A start pulse while busy is high is ignored: the running operation keeps its addresses, count and function.
- R10: func_sel 2'b11 behaves as pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| func_sel | input | 2 | 00 pass, 01 ReLU, 10 sigmoid, 11 pass |
| src_addr | input | ACC_AW | First accumulator address |
| dst_addr | input | UB_AW | First unified-buffer address |
| count | input | CNT_W | Number of vectors N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_rd_en | output | 1 | Accumulator read enable |
| acc_rd_addr | output | ACC_AW | Accumulator read address |
| acc_rd_data | input | LANES*32 | Accumulator read data, valid one cycle after the enable |
| ub_wr_en | output | 1 | Buffer write enable |
| ub_wr_addr | output | UB_AW | Buffer write address |
| ub_wr_data | output | LANES*8 | Buffer write data |

## Verification
The assertions assume that the accumulator memory returns data exactly one cycle after each read enable. They also assume that start is a single-cycle pulse, and that reset is held until the first checked edge. The bench models the accumulator as a registered lookup of a computed pattern, so the read latency is always one cycle. It drives start, the addresses and the count only on falling edges and for one cycle at a time. A start is issued while the block is busy only as the deliberate test of R9.

// File: rtl/act_pkg.sv
`timescale 1ns/1ps
package act_pkg;
  typedef enum logic [1:0] {
    FN_PASS = 2'b00,
    FN_RELU = 2'b01,
    FN_SIGM = 2'b10,
    FN_RSVD = 2'b11
  } act_fn_e;
endpackage

// File: rtl/act_lane.sv
`timescale 1ns/1ps
module act_lane #(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8,
  parameter int SIG_SHIFT = 2
) (
  input  act_pkg::act_fn_e     fn,
  input  logic [IN_W-1:0]      din,
  output logic [OUT_W-1:0]     dout
);
  localparam logic signed [IN_W:0] MID  = (IN_W+1)'(2**(OUT_W-1));
  localparam logic signed [IN_W:0] MAXV = (IN_W+1)'(2**OUT_W - 1);

  logic signed [IN_W:0] ext, shf, sum;
  logic [OUT_W-1:0] sig_q;

  always_comb begin
    ext = {din[IN_W-1], din};
    shf = ext >>> SIG_SHIFT;
    sum = shf + MID;
    if (sum < 0)         sig_q = '0;
    else if (sum > MAXV) sig_q = MAXV[OUT_W-1:0];
    else                 sig_q = sum[OUT_W-1:0];
  end

  always_comb begin
    unique case (fn)
      act_pkg::FN_RELU: dout = din[IN_W-1] ? '0 : din[OUT_W-1:0];
      act_pkg::FN_SIGM: dout = sig_q;
      default:          dout = din[OUT_W-1:0];
    endcase
  end
endmodule

// File: rtl/act_vector.sv
`timescale 1ns/1ps
module act_vector #(
  parameter int LANES     = 4,
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8,
  parameter int SIG_SHIFT = 2
) (
  input  act_pkg::act_fn_e         fn,
  input  logic [LANES*IN_W-1:0]    din,
  output logic [LANES*OUT_W-1:0]   dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    act_lane #(
      .IN_W(IN_W), .OUT_W(OUT_W), .SIG_SHIFT(SIG_SHIFT)
    ) u_lane (
      .fn  (fn),
      .din (din[g*IN_W +: IN_W]),
      .dout(dout[g*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/act_seq.sv
`timescale 1ns/1ps
module act_seq #(
  parameter int ACC_AW = 8,
  parameter int UB_AW  = 8,
  parameter int CNT_W  = ACC_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  act_pkg::act_fn_e   fn_in,
  input  logic [ACC_AW-1:0]  src_addr,
  input  logic [UB_AW-1:0]   dst_addr,
  input  logic [CNT_W-1:0]   count,
  output act_pkg::act_fn_e   fn_q,
  output logic               busy,
  output logic               done,
  output logic               rd_en,
  output logic [ACC_AW-1:0]  rd_addr,
  output logic               wr_en,
  output logic [UB_AW-1:0]   wr_addr
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q    <= act_pkg::FN_PASS;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      remain  <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= rd_en;
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (start && !busy) begin
        fn_q <= fn_in;
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          rd_en   <= 1'b1;
          rd_addr <= src_addr;
          remain  <= count - 1'b1;
          wr_addr <= dst_addr;
        end
      end else if (busy) begin
        if (rd_en) begin
          if (remain == '0) begin
            rd_en <= 1'b0;
          end else begin
            rd_addr <= rd_addr + 1'b1;
            remain  <= remain - 1'b1;
          end
        end
        if (wr_en && !rd_en) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/act_unit.sv
`timescale 1ns/1ps
module act_unit #(
  parameter int LANES     = 4,
  parameter int ACC_W     = 32,
  parameter int OUT_W     = 8,
  parameter int ACC_AW    = 8,
  parameter int UB_AW     = 8,
  parameter int CNT_W     = ACC_AW + 1,
  parameter int SIG_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               func_sel,
  input  logic [ACC_AW-1:0]        src_addr,
  input  logic [UB_AW-1:0]         dst_addr,
  input  logic [CNT_W-1:0]         count,
  output logic                     busy,
  output logic                     done,
  output logic                     acc_rd_en,
  output logic [ACC_AW-1:0]        acc_rd_addr,
  input  logic [LANES*ACC_W-1:0]   acc_rd_data,
  output logic                     ub_wr_en,
  output logic [UB_AW-1:0]         ub_wr_addr,
  output logic [LANES*OUT_W-1:0]   ub_wr_data
);
  act_pkg::act_fn_e fn_q;

  act_seq #(
    .ACC_AW(ACC_AW), .UB_AW(UB_AW), .CNT_W(CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .fn_in   (act_pkg::act_fn_e'(func_sel)),
    .src_addr(src_addr),
    .dst_addr(dst_addr),
    .count   (count),
    .fn_q    (fn_q),
    .busy    (busy),
    .done    (done),
    .rd_en   (acc_rd_en),
    .rd_addr (acc_rd_addr),
    .wr_en   (ub_wr_en),
    .wr_addr (ub_wr_addr)
  );

  act_vector #(
    .LANES(LANES), .IN_W(ACC_W), .OUT_W(OUT_W), .SIG_SHIFT(SIG_SHIFT)
  ) u_vec (
    .fn  (fn_q),
    .din (acc_rd_data),
    .dout(ub_wr_data)
  );
endmodule

// File: rtl/act_unit_chk.sv
`timescale 1ns/1ps
module act_unit_chk #(
  parameter int ACC_AW = 8,
  parameter int UB_AW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              acc_rd_en,
  input logic [ACC_AW-1:0] acc_rd_addr,
  input logic              ub_wr_en,
  input logic [UB_AW-1:0]  ub_wr_addr
);
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_rd_en && $past(acc_rd_en)) |-> (acc_rd_addr == ACC_AW'($past(acc_rd_addr) + 1'b1))); // R2
  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_rd_en |-> busy); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    acc_rd_en |=> ub_wr_en); // R3
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ub_wr_en && $past(ub_wr_en)) |-> (ub_wr_addr == UB_AW'($past(ub_wr_addr) + 1'b1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7
endmodule

bind act_unit act_unit_chk #(.ACC_AW(ACC_AW), .UB_AW(UB_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .acc_rd_en  (acc_rd_en),
  .acc_rd_addr(acc_rd_addr),
  .ub_wr_en   (ub_wr_en),
  .ub_wr_addr (ub_wr_addr)
);

// File: tb/act_unit_test.sv
`timescale 1ns/1ps
module act_unit_test;
  localparam int LANES = 4;
  localparam int AW    = 8;
  localparam int CW    = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] func_sel = 2'b00;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [CW-1:0] count = '0;
  logic busy, done, acc_rd_en, ub_wr_en;
  logic [AW-1:0] acc_rd_addr, ub_wr_addr;
  logic [LANES*32-1:0] acc_rd_data = '0;
  logic [LANES*8-1:0]  ub_wr_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic prev_rd = 1'b0;

  logic [AW-1:0]            rd_q[$];
  logic [AW+LANES*8-1:0]    wr_q[$];

  always #2.5 clk = ~clk;

  act_unit uut (
    .clk(clk), .rst(rst), .start(start), .func_sel(func_sel),
    .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
    .busy(busy), .done(done),
    .acc_rd_en(acc_rd_en), .acc_rd_addr(acc_rd_addr), .acc_rd_data(acc_rd_data),
    .ub_wr_en(ub_wr_en), .ub_wr_addr(ub_wr_addr), .ub_wr_data(ub_wr_data)
  );

  function automatic logic [31:0] pat(input logic [AW-1:0] a, input int e);
    logic [31:0] aa, ee;
    aa = 32'(a);
    ee = 32'(e);
    if (a < 32) return aa * 32'd8 - 32'd120 + ee * 32'd5;
    return (aa * 32'h9E3779B1) ^ (ee * 32'h7F4A7C15);
  endfunction

  function automatic logic [7:0] ref_byte(input logic [31:0] x, input logic [1:0] fn);
    longint s;
    case (fn)
      2'b01: return x[31] ? 8'd0 : x[7:0];
      2'b10: begin
        s = (longint'($signed(x)) >>> 2) + 128;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return 8'(s);
      end
      default: return x[7:0];
    endcase
  endfunction

  always_ff @(posedge clk) if (acc_rd_en) begin
    for (int e = 0; e < LANES; e++) acc_rd_data[e*32 +: 32] <= pat(acc_rd_addr, e);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares reads and writes against the scoreboard queues
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_rd_en) begin
        if (rd_q.size() == 0) chk(1'b0, "R2", "unexpected read", acc_rd_addr, 0);
        else begin
          logic [AW-1:0] ea;
          ea = rd_q.pop_front();
          chk(acc_rd_addr == ea, "R2", "read addr", acc_rd_addr, ea);
        end
      end
      if (ub_wr_en || prev_rd)
        chk(ub_wr_en == prev_rd, "R3", "write one cycle after read", ub_wr_en, prev_rd);
      if (ub_wr_en) begin
        if (wr_q.size() == 0) chk(1'b0, "R3", "unexpected write", ub_wr_addr, 0);
        else begin
          logic [AW+LANES*8-1:0] ew;
          ew = wr_q.pop_front();
          chk(ub_wr_addr == ew[LANES*8 +: AW], "R3", "write addr", ub_wr_addr, ew[LANES*8 +: AW]);
          chk(ub_wr_data == ew[LANES*8-1:0], "R4 R5 R6 R10", "write data",
              longint'(ub_wr_data), longint'(ew[LANES*8-1:0]));
        end
      end
      prev_rd <= acc_rd_en;
    end
  end

  // driver: pushes expectations, starts the operation, times busy and done
  task automatic run_op(input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input int n, input logic [1:0] fn, input bit intrude);
    int bc;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ra, wa;
      logic [LANES*8-1:0] v;
      ra = AW'(s + AW'(k));
      wa = AW'(d + AW'(k));
      for (int e = 0; e < LANES; e++) v[e*8 +: 8] = ref_byte(pat(ra, e), fn);
      rd_q.push_back(ra);
      wr_q.push_back({wa, v});
    end
    src_addr = s; dst_addr = d; count = CW'(n); func_sel = fn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    while (!done) begin
      if (busy) bc++;
      if (intrude && bc == 2) begin
        // R9: competing request while busy
        start = 1'b1; src_addr = 8'd0; dst_addr = 8'd0; count = 9'd7; func_sel = 2'b10;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(!busy, "R7", "busy low with done", busy, 0);
    chk(bc == (n == 0 ? 0 : n + 1), n == 0 ? "R8" : "R7", "busy cycles", bc, n == 0 ? 0 : n + 1);
    @(negedge clk);
    chk(!done, "R7", "done single pulse", done, 0);
    chk(rd_q.size() == 0 && wr_q.size() == 0, intrude ? "R9" : "R3", "pending items",
        rd_q.size() + wr_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !acc_rd_en && !ub_wr_en, "R1", "idle after reset",
        {busy, done, acc_rd_en, ub_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    run_op(8'd3,   8'd10,  4,  2'b00, 1'b0); // R4
    run_op(8'd20,  8'd0,   5,  2'b01, 1'b0); // R5
    run_op(8'd0,   8'd40,  16, 2'b10, 1'b0); // R6 linear region
    run_op(8'd100, 8'd60,  3,  2'b10, 1'b0); // R6 saturation
    run_op(8'd120, 8'd70,  6,  2'b01, 1'b0); // R5 large values
    run_op(8'd8,   8'd90,  2,  2'b11, 1'b0); // R10
    run_op(8'd5,   8'd5,   0,  2'b01, 1'b0); // R8
    run_op(8'd7,   8'd200, 1,  2'b00, 1'b0); // R7 single vector
    run_op(8'd10,  8'd30,  6,  2'b01, 1'b1); // R9
    run_op(8'd254, 8'd255, 4,  2'b00, 1'b0); // R2 R3 wrap
    run_op(8'd1,   8'd2,   3,  2'b10, 1'b0); // back-to-back
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule